// File: doc/BRIEF.md
# Companion I/O Controller

This block is a small peripheral on a byte-addressed processor bus. It decodes a 4 KiB offset window into a bank of 16-bit control registers and a 16-line general-purpose port. The control bank holds a mode word, a card-detect word, a card-control word, a power word, and three interrupt words: request, mask and status. It also holds a fixed status word and a general read-back word. These words are storage only. The block gives them no meaning beyond the power-word side effect described below.

The port has a direction word and a level word. The driven vector is the level word gated by the direction word. The block records that vector. After any bus write to the direction or level word, it puts the new vector on the pin outputs. In the cycle after that write, it also pulses a per-line change strobe for every line whose driven value moved. External agents can set or clear single level bits through per-line event inputs. These events update the level word quietly: they raise no strobe, and the pins keep their value until the next direction or level write.

Top module: `aux_io_ctrl`

## Requirements
- R1: Offsets are mode 0x000, card detect 0x004, status 0x008, power 0x00C, card control 0x010, interrupt request 0x014, interrupt mask 0x018, interrupt status 0x01C, direction 0x020, level 0x024 and read-back 0x028.
- R1 (continued): Each writable word reads back the last value written at its offset, through combinational read data while `cs` is high.
- R2: Read data is zero whenever `cs` is low.
- R3: A write to the power word stores the value. If bit 7 of the value is 1, bits 15 and 6 are also set, so the stored value is the value OR 0x8040.
- R4: A write to the level word stores the written value ANDed with the current direction word.
- R5: After a write to the direction or level word, `pin_lvl_o` equals level AND direction from the cycle after the write onward.
- R6: In the cycle after a direction or level write, `pin_chg_o` shows, for exactly one cycle, the bits where the new driven vector differs from the previous one. In every other cycle `pin_chg_o` is zero.
- R7: After reset, status reads 0x0002, and every other word, `pin_lvl_o` and `pin_chg_o` are zero.
- R8: Status is read-only. A write to 0x008 leaves it at 0x0002.
- R9: A read at any other offset, including offsets that are not multiples of four, returns zero. A write at such an offset changes no word.
- R10: For each line where `ext_vld_i` is 1, the level bit takes the value of `ext_lvl_i`. This happens with no strobe and no change on `pin_lvl_o`.
- R11: If a bus write to the level word lands in the same cycle as external events, the bus value wins on every bit.
- R12: A direction write can expose level bits that were set earlier by external events. Lines whose driven value changes because of this raise strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access select |
| we | input | 1 | Write when high, read when low |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| ext_vld_i | input | 16 | Per-line external level event |
| ext_lvl_i | input | 16 | Level carried by each event |
| pin_lvl_o | output | 16 | Driven level per line |
| pin_chg_o | output | 16 | One-cycle change strobe per line |

## Verification
The bench targets the places where the gated port is easy to get wrong.

- **Masking on level writes.** A design that skips the mask would show bits outside the direction word on read-back and on the pins.
- **Repeated level write.** Writing the same level twice must raise no strobe. A design that strobes on every write would fire here.
- **Quiet external events.** A design that drives the pins straight from the level word would move the pins or strobe here.
- **Collision cycle.** A bus write and external events land together. A design where events win would leave the event bits set.
- **Direction write that exposes event bits.** This catches designs whose strobe compares against the level word instead of the recorded driven vector.
- **Power, status and unmapped offsets.** A design that does not force the power bits, lets status be written, or decodes offsets only partly returns wrong read data.

// File: rtl/aux_io_pkg.sv
package aux_io_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned OFS_W = 12;

  localparam logic [REG_W-1:0] STATUS_RST = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
  localparam int unsigned      PWR_TRIG   = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL,
    SEL_IRQ_REQ, SEL_IRQ_MSK, SEL_IRQ_STS, SEL_DIR, SEL_LVL, SEL_RDBK
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      12'h000: decode_ofs = SEL_MODE;
      12'h004: decode_ofs = SEL_CDET;
      12'h008: decode_ofs = SEL_STAT;
      12'h00C: decode_ofs = SEL_PWR;
      12'h010: decode_ofs = SEL_CCTL;
      12'h014: decode_ofs = SEL_IRQ_REQ;
      12'h018: decode_ofs = SEL_IRQ_MSK;
      12'h01C: decode_ofs = SEL_IRQ_STS;
      12'h020: decode_ofs = SEL_DIR;
      12'h024: decode_ofs = SEL_LVL;
      12'h028: decode_ofs = SEL_RDBK;
      default: decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/aux_io_regs.sv
module aux_io_regs
  import aux_io_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_o
);
  localparam int unsigned NPLAIN = 7;

  function automatic int plain_idx(input reg_sel_e s);
    case (s)
      SEL_MODE:    plain_idx = 0;
      SEL_CDET:    plain_idx = 1;
      SEL_CCTL:    plain_idx = 2;
      SEL_IRQ_REQ: plain_idx = 3;
      SEL_IRQ_MSK: plain_idx = 4;
      SEL_IRQ_STS: plain_idx = 5;
      SEL_RDBK:    plain_idx = 6;
      default:     plain_idx = -1;
    endcase
  endfunction

  logic [W-1:0] plain_q [NPLAIN];
  logic [W-1:0] pwr_q, pwr_d;
  logic         pwr_en;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    logic en;
    always_comb en = wr_en && (plain_idx(sel) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  plain_q[i] <= '0;
      else if (en) plain_q[i] <= wdata;
    end
  end

  always_comb begin
    pwr_en = wr_en && (sel == SEL_PWR);
    pwr_d  = wdata[PWR_TRIG] ? (wdata | PWR_FORCE) : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= '0;
    else if (pwr_en) pwr_q <= pwr_d;
  end

  always_comb begin
    if (sel == SEL_PWR)          rd_o = pwr_q;
    else if (plain_idx(sel) >= 0) rd_o = plain_q[plain_idx(sel)];
    else                          rd_o = '0;
  end

  p_pwr_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PWR && wdata[PWR_TRIG]) |=> (pwr_q[15] && pwr_q[6]));
endmodule

// File: rtl/aux_io_gpio.sv
module aux_io_gpio #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             lvl_wr,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] ext_vld,
  input  logic [LINES-1:0] ext_lvl,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] lvl_q,
  output logic [LINES-1:0] out_o,
  output logic [LINES-1:0] chg_o
);
  logic [LINES-1:0] dir_d, lvl_d, eff_d;
  logic             upd;

  always_comb begin
    upd   = dir_wr || lvl_wr;
    dir_d = dir_wr ? wdata : dir_q;
    lvl_d = lvl_wr ? (wdata & dir_q)
                   : ((lvl_q & ~ext_vld) | (ext_lvl & ext_vld));
    eff_d = lvl_d & dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic chg_d;
    always_comb chg_d = upd && (eff_d[i] != out_o[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_o[i] <= 1'b0;
        chg_o[i] <= 1'b0;
      end else begin
        chg_o[i] <= chg_d;
        if (upd) out_o[i] <= eff_d[i];
      end
    end
  end

  p_lvl_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl_q & ~dir_q) == '0));
  p_out_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr || lvl_wr) |=> (out_o == (lvl_q & dir_q)));
  p_chg_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && !lvl_wr) |=> (chg_o == '0));
  p_ext_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && !lvl_wr) |=> $stable(out_o));
  p_bus_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_wr && ext_vld != '0) |=> (lvl_q == ($past(wdata) & dir_q)));
endmodule

// File: rtl/aux_io_ctrl.sv
module aux_io_ctrl
  import aux_io_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned ADDR_W = OFS_W,
  parameter int unsigned LINES  = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LINES-1:0]  ext_vld_i,
  input  logic [LINES-1:0]  ext_lvl_i,
  output logic [LINES-1:0]  pin_lvl_o,
  output logic [LINES-1:0]  pin_chg_o
);
  reg_sel_e         sel;
  logic             wr_en;
  logic [DATA_W-1:0] bank_rd;
  logic [LINES-1:0] dir_q, lvl_q;

  always_comb begin
    sel   = decode_ofs(addr);
    wr_en = cs && we;
  end

  aux_io_regs #(.W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wdata),
    .rd_o  (bank_rd)
  );

  aux_io_gpio #(.LINES(LINES)) u_gpio (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_wr  (wr_en && sel == SEL_DIR),
    .lvl_wr  (wr_en && sel == SEL_LVL),
    .wdata   (wdata[LINES-1:0]),
    .ext_vld (ext_vld_i),
    .ext_lvl (ext_lvl_i),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .out_o   (pin_lvl_o),
    .chg_o   (pin_chg_o)
  );

  always_comb begin
    rdata = '0;
    if (cs) begin
      case (sel)
        SEL_STAT: rdata = STATUS_RST;
        SEL_DIR:  rdata = DATA_W'(dir_q);
        SEL_LVL:  rdata = DATA_W'(lvl_q);
        SEL_NONE: rdata = '0;
        default:  rdata = bank_rd;
      endcase
    end
  end

  p_status_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sel == SEL_STAT) |-> (rdata == STATUS_RST));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sel == SEL_NONE) |-> (rdata == '0));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (rdata == '0));
endmodule

// File: tb/tb_aux_io_ctrl.sv
module tb_aux_io_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [15:0] ext_vld = '0, ext_lvl = '0, pin_lvl, pin_chg;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  aux_io_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_vld_i(ext_vld), .ext_lvl_i(ext_lvl),
    .pin_lvl_o(pin_lvl), .pin_chg_o(pin_chg)
  );

  // {write offset, write data, read offset, expected read}
  localparam logic [55:0] VEC [12] = '{
    {12'h000, 16'h1234, 12'h000, 16'h1234},  // R1 mode
    {12'h004, 16'hBEEF, 12'h004, 16'hBEEF},  // R1 card detect
    {12'h010, 16'h5A5A, 12'h010, 16'h5A5A},  // R1 card control
    {12'h014, 16'h8001, 12'h014, 16'h8001},  // R1 irq request
    {12'h018, 16'hFFFF, 12'h018, 16'hFFFF},  // R1 irq mask
    {12'h01C, 16'h1357, 12'h01C, 16'h1357},  // R1 irq status
    {12'h028, 16'h2468, 12'h028, 16'h2468},  // R1 read-back
    {12'h00C, 16'h0080, 12'h00C, 16'h80C0},  // R3 forced bits
    {12'h00C, 16'h0011, 12'h00C, 16'h0011},  // R3 no force
    {12'h008, 16'hFFFF, 12'h008, 16'h0002},  // R8 status read-only
    {12'h030, 16'h1234, 12'h030, 16'h0000},  // R9 unmapped
    {12'h002, 16'h9999, 12'h000, 16'h1234}   // R9 odd offset write leaves mode
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    cs = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    bus_rd(12'h008, r); check("R7 status", r, 16'h0002);
    bus_rd(12'h00C, r); check("R7 power", r, 16'h0000);
    bus_rd(12'h020, r); check("R7 dir", r, 16'h0000);
    check("R7 pins", pin_lvl, 16'h0000);
    check("R7 strobes", pin_chg, 16'h0000);
    check("R2 idle rdata", rdata, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      bus_wr(VEC[i][55:44], VEC[i][43:28]);
      bus_rd(VEC[i][27:16], r);
      check("R1/R3/R8/R9 vector", r, VEC[i][15:0]);
    end
    bus_rd(12'h002, r); check("R9 odd read", r, 16'h0000);

    // GPIO
    bus_wr(12'h020, 16'h00FF);
    check("R6 dir no change", pin_chg, 16'h0000);
    check("R5 pins", pin_lvl, 16'h0000);
    bus_wr(12'h024, 16'hF0F3);
    check("R6 strobe", pin_chg, 16'h00F3);
    check("R5 pins", pin_lvl, 16'h00F3);
    bus_rd(12'h024, r); check("R4 masked level", r, 16'h00F3);
    @(negedge clk);
    check("R6 one cycle", pin_chg, 16'h0000);
    bus_wr(12'h024, 16'h00F3);
    check("R6 same value no strobe", pin_chg, 16'h0000);

    ext_vld = 16'hFF01; ext_lvl = 16'h0100;
    @(negedge clk);
    ext_vld = '0; ext_lvl = '0;
    check("R10 no strobe", pin_chg, 16'h0000);
    check("R10 pins held", pin_lvl, 16'h00F3);
    bus_rd(12'h024, r); check("R10 level updated", r, 16'h01F2);

    bus_wr(12'h020, 16'hFFFF);
    check("R12 exposed strobe", pin_chg, 16'h0101);
    check("R12 pins", pin_lvl, 16'h01F2);

    ext_vld = 16'hFFFF; ext_lvl = 16'hFFFF;
    bus_wr(12'h024, 16'h000F);
    ext_vld = '0; ext_lvl = '0;
    bus_rd(12'h024, r); check("R11 bus wins", r, 16'h000F);
    check("R11 strobe", pin_chg, 16'h01FD);
    check("R5 pins", pin_lvl, 16'h000F);

    bus_wr(12'h020, 16'h0003);
    check("R6 dir shrink strobe", pin_chg, 16'h000C);
    check("R5 pins", pin_lvl, 16'h0003);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule